// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

The walker turns a 64-bit virtual address into a real page address. It walks a hierarchy of up to five translation tables: three region tables, a segment table and a page table. The caller gives the address, the kind of access (read, write or instruction fetch), the address-space mode, the translation-enable and 64-bit-addressing flags, and the three control registers that hold the table designations. The walker picks one designation from the mode. It checks that the address fits the top table named by that designation. It then fetches one table entry per level through a simple request/response read port, until it reaches a page frame or hits a fault.

Each translation ends with a one-cycle `done` pulse. The pulse carries the real page address, read/write/execute permission flags, an 8-bit exception code and an exception address word. The exception address word is the faulting page address, tagged with the address-space mode and, for a protection fault, with a protection flag. Only one walk runs at a time. `busy` is high while table reads are in flight.

Top module: `dat_walker`

## Requirements
- R1: When `dat_on` is 0, `done` rises one cycle after the request is accepted. `real_addr` is the virtual address with its low 12 bits cleared, `perm` is 3'b111 (bit 2 read, bit 1 write, bit 0 execute), `exc_code` is 0 and no table read is issued.
- R2: When `addr64` is 0, the virtual address is ANDed with 0x7fffffff before any other use, whether translation is on or off.
- R3: `req_mode` selects the designation: 2'd1 primary (`ctl1_desig`), 2'd2 secondary (`ctl7_desig`), 2'd3 home (`ctl13_desig`). Mode 2'd0 behaves exactly as primary.
- R4: Designation bits [3:2] give the top table type: 3 region-first, 2 region-second, 1 region-third, 0 segment. For type 2 the address bits under mask 0xffe0000000000000 must be zero. For type 1 the mask is 0xfffffc0000000000, and for type 0 it is 0xffffffff80000000. Any other value raises code 0x12 and issues no table read.
- R5: If bit 5 of the selected designation is set, the page-aligned virtual address is returned as the real address and no table read is issued.
- R6: The walk starts at the table named by the type. Each entry is read at origin plus a byte offset: region-first (va>>50)&0x3ff8, region-second (va>>39)&0x3ff8, region-third (va>>28)&0x3ff8, segment (va>>17)&0x3ff8, page (va>>9)&0x7f8. The origin is designation/entry bits [63:12], except that a segment entry's page-table origin is bits [63:11]. A page entry's bits [63:12] give the real page address.
- R7: A region or segment entry with bit 5 set raises code 0x10 (segment translation). This check is made before the type check.
- R8: A region or segment entry whose bits [3:2] differ from the type of the table it was read from raises code 0x12.
- R9: A page entry with bit 10 set raises code 0x11 (page translation).
- R10: A page entry with bit 9 set clears write permission. A write access to that page instead raises code 0x04, with bit 2 of `exc_word` set.
- R11: In secondary mode, an instruction fetch (`req_acc`=2) uses the primary designation and returns only execute permission. Data accesses (0 read, 1 write) use the secondary designation and lose execute permission.
- R12: On a fault, `exc_word` is the page-aligned virtual address ORed with 1 (primary), 2 (secondary) or 3 (home), naming the designation actually used.
- R13: `busy` is high from acceptance of a walking request until its result. A request presented while busy is ignored. `mem_req_valid` and `mem_req_addr` hold steady until `mem_rsp_valid`.
- R14: On a fault `real_addr` and `perm` are 0. On success `exc_code` and `exc_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode |
| dat_on | input | 1 | Translation enable |
| addr64 | input | 1 | 64-bit addressing (0 = 31-bit) |
| ctl1_desig | input | 64 | Primary designation |
| ctl7_desig | input | 64 | Secondary designation |
| ctl13_desig | input | 64 | Home designation |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 64 | Table entry |
| done | output | 1 | Result pulse |
| real_addr | output | 64 | Real page address |
| perm | output | 3 | Permission flags {read, write, execute} |
| exc_code | output | 8 | Exception code, 0 for none |
| exc_word | output | 64 | Exception address word |

## Verification
Faults at one particular level cannot be reached from the request port alone, because they need a valid chain that is broken at exactly that level. The bench builds a fresh chain of tables for each case in its memory model. It then corrupts a single entry: it sets the invalid bit on a region entry, sets both invalid and a wrong type on a segment entry, gives a region-third entry a wrong type, or sets the invalid or read-only bit on a page entry. The ignore-while-busy case needs a walk held open. The memory model stretches its response latency so that a second request can be presented mid-walk.

// File: rtl/dat_pkg.sv
package dat_pkg;
   localparam logic [1:0] ACC_RD    = 2'd0;
   localparam logic [1:0] ACC_WR    = 2'd1;
   localparam logic [1:0] ACC_FETCH = 2'd2;

   localparam logic [1:0] MODE_PRI  = 2'd1;
   localparam logic [1:0] MODE_SEC  = 2'd2;
   localparam logic [1:0] MODE_HOME = 2'd3;

   localparam logic [2:0] PERM_R   = 3'b100;
   localparam logic [2:0] PERM_W   = 3'b010;
   localparam logic [2:0] PERM_X   = 3'b001;
   localparam logic [2:0] PERM_ALL = 3'b111;

   localparam logic [7:0] EXC_NONE = 8'h00;
   localparam logic [7:0] EXC_PROT = 8'h04;
   localparam logic [7:0] EXC_SEG  = 8'h10;
   localparam logic [7:0] EXC_PAGE = 8'h11;
   localparam logic [7:0] EXC_SPEC = 8'h12;
endpackage

// File: rtl/dat_desig_sel.sv
module dat_desig_sel
   import dat_pkg::*;
#(
   parameter int VA_W = 64
) (
   input  logic [1:0]      mode,
   input  logic [1:0]      acc,
   input  logic [VA_W-1:0] c_pri,
   input  logic [VA_W-1:0] c_sec,
   input  logic [VA_W-1:0] c_home,
   output logic [VA_W-1:0] desig,
   output logic [1:0]      mbits,
   output logic [2:0]      pmask
);
   always_comb begin
      desig = c_pri;
      mbits = MODE_PRI;
      pmask = PERM_ALL;
      case (mode)
         MODE_SEC: begin
            if (acc == ACC_FETCH) begin
               desig = c_pri;
               mbits = MODE_PRI;
               pmask = PERM_X;
            end else begin
               desig = c_sec;
               mbits = MODE_SEC;
               pmask = PERM_R | PERM_W;
            end
         end
         MODE_HOME: begin
            desig = c_home;
            mbits = MODE_HOME;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dat_range_chk.sv
module dat_range_chk #(
   parameter int VA_W = 64
) (
   input  logic [1:0]      top_type,
   input  logic [VA_W-1:0] va,
   output logic            bad
);
   localparam logic [VA_W-1:0] LIM_R2  = {{11{1'b1}}, {(VA_W-11){1'b0}}};
   localparam logic [VA_W-1:0] LIM_R3  = {{22{1'b1}}, {(VA_W-22){1'b0}}};
   localparam logic [VA_W-1:0] LIM_SEG = {{33{1'b1}}, {(VA_W-33){1'b0}}};

   generate
      if (VA_W != 64) begin : g_bad_width
         $error("dat_range_chk: VA_W must be 64");
      end
   endgenerate

   always_comb begin
      case (top_type)
         2'd2:    bad = |(va & LIM_R2);
         2'd1:    bad = |(va & LIM_R3);
         2'd0:    bad = |(va & LIM_SEG);
         default: bad = 1'b0;
      endcase
   end
endmodule

// File: rtl/dat_tbl_offset.sv
module dat_tbl_offset #(
   parameter int VA_W   = 64,
   parameter int LVL_N  = 5,
   parameter int LVL_W  = 3,
   parameter int OFFS_W = 14
) (
   input  logic [VA_W-1:0]   va,
   input  logic [LVL_W-1:0]  lvl,
   output logic [OFFS_W-1:0] offs
);
   logic [OFFS_W-1:0] offs_lv [LVL_N];

   generate
      if (6 + 11*(LVL_N-1) >= VA_W || (1 << LVL_W) < LVL_N) begin : g_bad_cfg
         $error("dat_tbl_offset: level count does not fit the address");
      end
      for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
         localparam int SH = (g == 0) ? 9 : 6 + 11*g;
         localparam logic [OFFS_W-1:0] MSK = (g == 0) ? OFFS_W'(12'h7f8) : OFFS_W'(16'h3ff8);
         logic [VA_W-1:0] shifted;
         assign shifted    = va >> SH;
         assign offs_lv[g] = shifted[OFFS_W-1:0] & MSK;
      end
   endgenerate

   always_comb begin
      offs = '0;
      for (int i = 0; i < LVL_N; i++) begin
         if (lvl == LVL_W'(i)) offs = offs_lv[i];
      end
   end
endmodule

// File: rtl/dat_walker.sv
module dat_walker
   import dat_pkg::*;
#(
   parameter int VA_W        = 64,
   parameter int PG_SHIFT    = 12,
   parameter int PT_ALIGN    = 11,
   parameter int INV_BIT     = 5,
   parameter int RSPACE_BIT  = 5,
   parameter int PTE_INV_BIT = 10,
   parameter int PTE_RO_BIT  = 9,
   parameter int LVL_N       = 5,
   parameter int LVL_W       = 3,
   parameter int OFFS_W      = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [63:0]     req_vaddr,
   input  logic [1:0]      req_acc,
   input  logic [1:0]      req_mode,
   input  logic            dat_on,
   input  logic            addr64,
   input  logic [63:0]     ctl1_desig,
   input  logic [63:0]     ctl7_desig,
   input  logic [63:0]     ctl13_desig,
   output logic            busy,
   output logic            mem_req_valid,
   output logic [63:0]     mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [63:0]     mem_rsp_data,
   output logic            done,
   output logic [63:0]     real_addr,
   output logic [2:0]      perm,
   output logic [7:0]      exc_code,
   output logic [63:0]     exc_word
);
   localparam logic [VA_W-1:0] PG_MASK  = {{(VA_W-PG_SHIFT){1'b1}}, {PG_SHIFT{1'b0}}};
   localparam logic [VA_W-1:0] PT_MASK  = {{(VA_W-PT_ALIGN){1'b1}}, {PT_ALIGN{1'b0}}};
   localparam logic [VA_W-1:0] LOW31    = VA_W'(32'h7fff_ffff);
   localparam logic [VA_W-1:0] PROT_TAG = VA_W'(4);

   generate
      if (VA_W != 64 || PG_SHIFT != 12 || PT_ALIGN >= PG_SHIFT) begin : g_bad_cfg
         $error("dat_walker: unsupported address or page geometry");
      end
   endgenerate

   typedef enum logic {S_IDLE, S_MEM} st_e;

   st_e              st_q, nxt_st;
   logic [VA_W-1:0]  va_in, va_pg, va_q, org_q, nxt_org;
   logic [LVL_W-1:0] lvl_q, nxt_lvl;
   logic [1:0]       acc_q, mbits_q;
   logic [2:0]       pmask_q;
   logic [VA_W-1:0]  sel_desig;
   logic [1:0]       sel_bits;
   logic [2:0]       sel_pmask;
   logic             range_bad;
   logic [OFFS_W-1:0] offs;
   logic             fin;
   logic [VA_W-1:0]  f_real, f_word;
   logic [2:0]       f_perm;
   logic [7:0]       f_exc;
   logic             ent_inv, pte_inv, pte_ro;
   logic [1:0]       ent_type;

   assign va_in = addr64 ? req_vaddr : (req_vaddr & LOW31);
   assign va_pg = va_in & PG_MASK;

   dat_desig_sel #(.VA_W(VA_W)) i_sel (
      .mode(req_mode), .acc(req_acc),
      .c_pri(ctl1_desig), .c_sec(ctl7_desig), .c_home(ctl13_desig),
      .desig(sel_desig), .mbits(sel_bits), .pmask(sel_pmask)
   );

   dat_range_chk #(.VA_W(VA_W)) i_rng (
      .top_type(sel_desig[3:2]), .va(va_pg), .bad(range_bad)
   );

   dat_tbl_offset #(.VA_W(VA_W), .LVL_N(LVL_N), .LVL_W(LVL_W), .OFFS_W(OFFS_W)) i_offs (
      .va(va_q), .lvl(lvl_q), .offs(offs)
   );

   assign ent_inv  = mem_rsp_data[INV_BIT];
   assign ent_type = mem_rsp_data[3:2];
   assign pte_inv  = mem_rsp_data[PTE_INV_BIT];
   assign pte_ro   = mem_rsp_data[PTE_RO_BIT];

   always_comb begin
      fin     = 1'b0;
      f_real  = '0;
      f_perm  = '0;
      f_exc   = EXC_NONE;
      f_word  = '0;
      nxt_st  = st_q;
      nxt_lvl = lvl_q;
      nxt_org = org_q;
      case (st_q)
         S_IDLE: begin
            if (req_valid) begin
               if (!dat_on) begin
                  fin    = 1'b1;
                  f_real = va_pg;
                  f_perm = PERM_ALL;
               end else if (range_bad) begin
                  fin    = 1'b1;
                  f_exc  = EXC_SPEC;
                  f_word = va_pg | VA_W'(sel_bits);
               end else if (sel_desig[RSPACE_BIT]) begin
                  fin    = 1'b1;
                  f_real = va_pg;
                  f_perm = PERM_ALL & sel_pmask;
               end else begin
                  nxt_st  = S_MEM;
                  nxt_lvl = LVL_W'(sel_desig[3:2]) + LVL_W'(1);
                  nxt_org = sel_desig & PG_MASK;
               end
            end
         end
         S_MEM: begin
            if (mem_rsp_valid) begin
               if (lvl_q != '0) begin
                  if (ent_inv) begin
                     fin    = 1'b1;
                     f_exc  = EXC_SEG;
                     f_word = va_q | VA_W'(mbits_q);
                  end else if (LVL_W'(ent_type) != lvl_q - LVL_W'(1)) begin
                     fin    = 1'b1;
                     f_exc  = EXC_SPEC;
                     f_word = va_q | VA_W'(mbits_q);
                  end else begin
                     nxt_lvl = lvl_q - LVL_W'(1);
                     nxt_org = (lvl_q == LVL_W'(1)) ? (mem_rsp_data & PT_MASK)
                                                    : (mem_rsp_data & PG_MASK);
                  end
               end else if (pte_inv) begin
                  fin    = 1'b1;
                  f_exc  = EXC_PAGE;
                  f_word = va_q | VA_W'(mbits_q);
               end else if (pte_ro && acc_q == ACC_WR) begin
                  fin    = 1'b1;
                  f_exc  = EXC_PROT;
                  f_word = va_q | VA_W'(mbits_q) | PROT_TAG;
               end else begin
                  fin    = 1'b1;
                  f_real = mem_rsp_data & PG_MASK;
                  f_perm = (pte_ro ? (PERM_ALL & ~PERM_W) : PERM_ALL) & pmask_q;
               end
               if (fin) nxt_st = S_IDLE;
            end
         end
         default: nxt_st = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         lvl_q     <= '0;
         org_q     <= '0;
         va_q      <= '0;
         acc_q     <= ACC_RD;
         mbits_q   <= MODE_PRI;
         pmask_q   <= PERM_ALL;
         done      <= 1'b0;
         real_addr <= '0;
         perm      <= '0;
         exc_code  <= EXC_NONE;
         exc_word  <= '0;
      end else begin
         st_q  <= nxt_st;
         lvl_q <= nxt_lvl;
         org_q <= nxt_org;
         if (st_q == S_IDLE && req_valid) begin
            va_q    <= va_pg;
            acc_q   <= req_acc;
            mbits_q <= sel_bits;
            pmask_q <= sel_pmask;
         end
         done <= fin;
         if (fin) begin
            real_addr <= f_real;
            perm      <= f_perm;
            exc_code  <= f_exc;
            exc_word  <= f_word;
         end
      end
   end

   assign busy          = (st_q == S_MEM);
   assign mem_req_valid = (st_q == S_MEM);
   assign mem_req_addr  = org_q + VA_W'(offs);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr)); // R13
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R13
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_code != EXC_NONE |-> real_addr == '0 && perm == '0); // R14
   AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_code == EXC_NONE |-> exc_word == '0); // R14
   AST_PROT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_code == EXC_PROT |-> exc_word[2]); // R10
   AST_MODE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_code != EXC_NONE |-> exc_word[1:0] != 2'b00); // R12
endmodule

// File: tb/test_dat_walker.sv
module test_dat_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_acc = '0;
   logic [1:0]  req_mode = 2'd1;
   logic        dat_on = 1'b0;
   logic        addr64 = 1'b1;
   logic [63:0] ctl1_desig = '0, ctl7_desig = '0, ctl13_desig = '0;
   logic        busy, mem_req_valid, mem_rsp_valid = 1'b0, done;
   logic [63:0] mem_req_addr, mem_rsp_data = '0, real_addr, exc_word;
   logic [2:0]  perm;
   logic [7:0]  exc_code;

   always #5 clk = ~clk;

   dat_walker i_dat_walker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_acc(req_acc), .req_mode(req_mode), .dat_on(dat_on), .addr64(addr64),
      .ctl1_desig(ctl1_desig), .ctl7_desig(ctl7_desig), .ctl13_desig(ctl13_desig),
      .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
      .real_addr(real_addr), .perm(perm), .exc_code(exc_code), .exc_word(exc_word)
   );

   typedef struct {
      logic [63:0] ra;
      logic [2:0]  pm;
      logic [7:0]  ex;
      logic [63:0] wd;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          n_run = 0, n_fail = 0, n_done = 0, rd_cnt = 0, lat = 0;
   logic [63:0] mem [logic [63:0]];
   logic [63:0] ent_addr [5];
   logic [63:0] next_tbl = 64'h0010_0000;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // memory model: level-held request, one-cycle response after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mem_req_valid) begin
            logic [63:0] a;
            a = mem_req_addr;
            repeat (lat) @(negedge clk);
            mem_rsp_data  = mem.exists(a) ? mem[a] : 64'h420;
            mem_rsp_valid = 1'b1;
            rd_cnt++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // monitor: pops the scoreboard on each result
   always @(negedge clk) begin
      if (rst_n && done) begin
         n_done++;
         if (sb.size() == 0) begin
            n_run++;
            n_fail++;
            $display("FAIL R13 unexpected result actual=%h expected=none", real_addr);
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (real_addr !== e.ra || perm !== e.pm || exc_code !== e.ex || exc_word !== e.wd) begin
               n_fail++;
               $display("FAIL %s actual real=%h perm=%b exc=%h word=%h expected real=%h perm=%b exc=%h word=%h",
                        e.tag, real_addr, perm, exc_code, exc_word, e.ra, e.pm, e.ex, e.wd);
            end
         end
      end
   end

   function automatic logic [63:0] offs(input int lv, input logic [63:0] va);
      case (lv)
         4: return (va >> 50) & 64'h3ff8;
         3: return (va >> 39) & 64'h3ff8;
         2: return (va >> 28) & 64'h3ff8;
         1: return (va >> 17) & 64'h3ff8;
         default: return (va >> 9) & 64'h7f8;
      endcase
   endfunction

   function automatic logic [63:0] alloc();
      next_tbl = next_tbl + 64'h10000;
      return next_tbl;
   endfunction

   // build a fresh chain; returns designation with type field set
   task automatic build(input int top, input logic [63:0] va, input logic [63:0] frame,
                        input bit ro, output logic [63:0] des);
      logic [63:0] org, child, a;
      org = alloc();
      des = org | (64'(top) << 2);
      for (int lv = top + 1; lv >= 1; lv--) begin
         child = alloc();
         a = org + offs(lv, va);
         mem[a] = child | (64'(lv - 1) << 2);
         ent_addr[lv] = a;
         org = child;
      end
      a = org + offs(0, va);
      mem[a] = frame | (ro ? 64'h200 : 64'h0);
      ent_addr[0] = a;
   endtask

   task automatic run(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                      input bit don, input bit a64, input logic [63:0] er, input logic [2:0] ep,
                      input logic [7:0] ee, input logic [63:0] ew, input string tag);
      exp_t e;
      e.ra = er; e.pm = ep; e.ex = ee; e.wd = ew; e.tag = tag;
      while (busy) @(negedge clk);
      sb.push_back(e);
      @(negedge clk);
      req_vaddr = va; req_acc = acc; req_mode = mode; dat_on = don; addr64 = a64;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (sb.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] d1, d, va4, va6, va7, vb, v13, v18;
      int rc, dn;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && mem_req_valid === 1'b0, "R13 reset state",
          {61'b0, busy, done, mem_req_valid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 translation off
      rc = rd_cnt;
      run(64'h1234_5678_9abc_def0, 2'd0, 2'd1, 0, 1, 64'h1234_5678_9abc_d000, 3'b111, 8'h00, 0, "R1 dat off");
      run(64'h1234_5678_9abc_def0, 2'd1, 2'd1, 0, 0, 64'h0000_0000_1abc_d000, 3'b111, 8'h00, 0, "R2 31-bit dat off");
      chk(rd_cnt == rc, "R1 no table read", 64'(rd_cnt), 64'(rc));

      // R6 R3 five-level walk through primary
      va4 = 64'h0123_4567_89ab_c000;
      build(3, va4, 64'h0000_0000_00ab_c000, 0, d1);
      ctl1_desig = d1;
      run(va4, 2'd0, 2'd1, 1, 1, 64'h00ab_c000, 3'b111, 8'h00, 0, "R6 R3 region-first walk");
      lat = 3;
      run(va4, 2'd1, 2'd1, 1, 1, 64'h00ab_c000, 3'b111, 8'h00, 0, "R6 write with latency");
      lat = 1;
      run(va4, 2'd2, 2'd2, 1, 1, 64'h00ab_c000, 3'b001, 8'h00, 0, "R11 secondary fetch uses primary");

      // home with region-third top
      va6 = 64'h0000_0123_4567_8000;
      build(1, va6, 64'h00cd_e000, 0, d);
      ctl13_desig = d;
      run(va6, 2'd0, 2'd3, 1, 1, 64'h00cd_e000, 3'b111, 8'h00, 0, "R3 R6 home region-third");
      run(64'h0000_0400_0000_0000, 2'd0, 2'd3, 1, 1, 0, 3'b000, 8'h12, 64'h0000_0400_0000_0003, "R4 R12 region-third range");

      // secondary data with segment top
      va7 = 64'h0000_0000_1234_5000;
      build(0, va7, 64'h0777_0000, 0, d);
      ctl7_desig = d;
      run(va7, 2'd0, 2'd2, 1, 1, 64'h0777_0000, 3'b110, 8'h00, 0, "R11 secondary data");
      run(64'hffff_ffff_9234_5abc, 2'd0, 2'd2, 1, 0, 64'h0777_0000, 3'b110, 8'h00, 0, "R2 31-bit walk");
      rc = rd_cnt;
      run(64'h0000_0000_8000_0000, 2'd0, 2'd2, 1, 1, 0, 3'b000, 8'h12, 64'h0000_0000_8000_0002, "R4 R12 segment range");
      chk(rd_cnt == rc, "R4 no table read", 64'(rd_cnt), 64'(rc));

      // region-second top
      vb = 64'h000a_bcde_f000_0000;
      build(2, vb, 64'h0055_5000, 0, d);
      ctl1_desig = d;
      run(vb, 2'd0, 2'd1, 1, 1, 64'h0055_5000, 3'b111, 8'h00, 0, "R6 region-second walk");
      run(64'h0020_0000_0000_0000, 2'd0, 2'd1, 1, 1, 0, 3'b000, 8'h12, 64'h0020_0000_0000_0001, "R4 region-second range");

      // real space
      ctl13_desig = 64'h9000 | (64'd3 << 2) | 64'h20;
      rc = rd_cnt;
      run(64'h5555_0000_1234_5678, 2'd0, 2'd3, 1, 1, 64'h5555_0000_1234_5000, 3'b111, 8'h00, 0, "R5 real space");
      chk(rd_cnt == rc, "R5 no table read", 64'(rd_cnt), 64'(rc));

      // entry faults
      v13 = 64'h0abc_0000_0000_0000;
      build(3, v13, 64'h0001_0000, 0, d); ctl1_desig = d;
      mem[ent_addr[3]] = mem[ent_addr[3]] | 64'h20;
      run(v13, 2'd0, 2'd1, 1, 1, 0, 3'b000, 8'h10, v13 | 64'd1, "R7 invalid region entry");
      build(3, v13, 64'h0001_0000, 0, d); ctl1_desig = d;
      mem[ent_addr[1]] = mem[ent_addr[1]] | 64'h20 | 64'hc;
      run(v13, 2'd0, 2'd1, 1, 1, 0, 3'b000, 8'h10, v13 | 64'd1, "R7 invalid before type");
      build(3, v13, 64'h0001_0000, 0, d); ctl1_desig = d;
      mem[ent_addr[2]] = (mem[ent_addr[2]] & ~64'hc) | 64'h8;
      run(v13, 2'd0, 2'd1, 1, 1, 0, 3'b000, 8'h12, v13 | 64'd1, "R8 type mismatch");
      build(3, v13, 64'h0001_0000, 0, d); ctl1_desig = d;
      mem[ent_addr[0]] = mem[ent_addr[0]] | 64'h400;
      run(v13, 2'd0, 2'd1, 1, 1, 0, 3'b000, 8'h11, v13 | 64'd1, "R9 invalid page");

      // read-only page
      build(3, v13, 64'h0002_0000, 1, d); ctl1_desig = d;
      run(v13, 2'd0, 2'd1, 1, 1, 64'h0002_0000, 3'b101, 8'h00, 0, "R10 read-only read");
      run(v13, 2'd1, 2'd1, 1, 1, 0, 3'b000, 8'h04, v13 | 64'd5, "R10 R12 write protection");
      run(v13, 2'd1, 2'd0, 1, 1, 0, 3'b000, 8'h04, v13 | 64'd5, "R3 mode zero as primary");
      v18 = 64'h0000_0000_3456_7000;
      build(0, v18, 64'h0003_0000, 1, d); ctl7_desig = d;
      run(v18, 2'd1, 2'd2, 1, 1, 0, 3'b000, 8'h04, v18 | 64'd6, "R12 secondary protection tag");

      // R13 request while busy is ignored
      ctl1_desig = d1;
      lat = 3;
      dn = n_done;
      begin
         exp_t e;
         e.ra = 64'h00ab_c000; e.pm = 3'b111; e.ex = 8'h00; e.wd = 0; e.tag = "R13 walk under second request";
         sb.push_back(e);
      end
      @(negedge clk);
      req_vaddr = va4; req_acc = 2'd0; req_mode = 2'd1; dat_on = 1'b1; addr64 = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R13 busy during walk", {63'b0, busy}, 64'h1);
      @(negedge clk);
      req_vaddr = 64'h0; dat_on = 1'b0; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
      while (sb.size() != 0 || busy) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(n_done == dn + 1, "R13 single result", 64'(n_done - dn), 64'd1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule